// File: doc/BRIEF.md
# Host/DSP Command-Reply Mailbox

This block links a host processor and a DSP through three independent mailbox lanes. Each lane holds one 16-bit command word and one 16-bit reply word. The host writes the command and the DSP reads it. The DSP writes the reply and the host reads it. Both sides reach a lane through a plain register port: a lane index, a write strobe, a read strobe and a data bus.

Each word has a handshake flag that is active low. A command flag drops to 0 once the DSP has read the command. A host write sets it back to 1. A reply flag drops to 0 once the DSP has written a new reply. A host read sets it back to 1.

The six flags appear at fixed positions in a 16-bit status word. Host software polls that word. Each reply lane has its own interrupt enable. The interrupt output is a level: it stays high while any enabled lane has an unread reply.

Top module: `dsp_mailbox`

## Requirements
- R1: After a synchronous reset, every command and reply word reads 0, all six flags read 1, the status word reads 0xFC00 and `irq` is low.
- R2: A host write strobe to lane c (c in 0..2) stores `host_wdata` as that lane's command. From the next cycle the command appears on `dsp_rdata` when `dsp_addr`=c, and status bit 13+c reads 1.
- R3: A DSP read strobe on lane c, with no host write to lane c in the same cycle, clears status bit 13+c to 0 in the next cycle. The command word does not change.
- R4: A DSP write strobe to lane c stores `dsp_wdata` as that lane's reply. From the next cycle the reply appears on `host_rdata` when `host_addr`=c, and status bit 10+c reads 0.
- R5: A host read strobe on lane c, with no DSP write to lane c in the same cycle, sets status bit 10+c to 1 in the next cycle. The reply word does not change.
- R6: When a host write and a DSP read hit the same command in one cycle, the new data is stored and the command flag ends at 1.
- R7: When a DSP write and a host read hit the same reply in one cycle, the new data is stored and the reply flag ends at 0.
- R8: `irq` is high exactly when some lane c has `irq_en[c]`=1 and status bit 10+c at 0. It follows changes of `irq_en` in the same cycle.
- R9: An access to one lane changes no word and no flag of any other lane.
- R10: A lane index of 3 or more is ignored on both ports. It changes no word and no flag, and `host_rdata` and `dsp_rdata` read 0 for it.
- R11: Status bits 0 to 9 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 2 | Host lane index |
| host_wr_en | input | 1 | Host write strobe to the command word |
| host_rd_en | input | 1 | Host read strobe for the reply word (acknowledge) |
| host_wdata | input | 16 | Command data from the host |
| host_rdata | output | 16 | Reply word of the addressed lane |
| irq_en | input | 3 | Per-lane reply interrupt enable |
| status | output | 16 | Bits 10-12 reply flags, bits 13-15 command flags |
| irq | output | 1 | Level interrupt to the host |
| dsp_addr | input | 2 | DSP lane index |
| dsp_wr_en | input | 1 | DSP write strobe to the reply word |
| dsp_rd_en | input | 1 | DSP read strobe for the command word (acknowledge) |
| dsp_wdata | input | 16 | Reply data from the DSP |
| dsp_rdata | output | 16 | Command word of the addressed lane |

## Verification
Each lane is driven with a walking one in all 16 bit positions, mixed with a lane-specific pattern. A stuck or swapped data bit, or a lane decode error, shows up as a mismatch on one of the two read buses. All 64 combinations of enable mask and pending-reply pattern are applied, so every term of the interrupt equation is tested on its own. Same-cycle collisions on the same lane and on different lanes show which side wins each flag. Accesses to the unused index 3 show that nothing leaks into the real lanes.

// File: rtl/dsp_mbox_pkg.sv
package dsp_mbox_pkg;

    localparam int STATUS_W      = 16;
    localparam int REPLY_FLAG_LO = 10;
    localparam int CMD_FLAG_LO   = 13;
    localparam int MAX_LANES     = 3;

    // Per-lane strobes after index decode.
    typedef struct packed {
        logic host_put_cmd;
        logic dsp_take_cmd;
        logic dsp_put_rep;
        logic host_take_rep;
    } lane_ops_t;

    // Active-low handshake flags of one lane.
    typedef struct packed {
        logic cmd_fresh_n;   // 0: DSP has read the command
        logic rep_fresh_n;   // 0: DSP has written a new reply
    } lane_flags_t;

    function automatic logic lane_hit(input logic en, input int unsigned idx,
                                      input int unsigned lane);
        return en && (idx == lane);
    endfunction

endpackage

// File: rtl/dsp_mbox_lane.sv
module dsp_mbox_lane
    import dsp_mbox_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  lane_ops_t         ops,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] dsp_wdata,
    output logic [DATA_W-1:0] cmd_word,
    output logic [DATA_W-1:0] rep_word,
    output lane_flags_t       flags
);

    logic cmd_n_q;
    logic rep_n_q;

    // Command side: a host write wins over a DSP read in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_word <= '0;
            cmd_n_q  <= 1'b1;
        end else if (ops.host_put_cmd) begin
            cmd_word <= host_wdata;
            cmd_n_q  <= 1'b1;
        end else if (ops.dsp_take_cmd) begin
            cmd_n_q  <= 1'b0;
        end
    end

    // Reply side: a DSP write wins over a host read in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            rep_word <= '0;
            rep_n_q  <= 1'b1;
        end else if (ops.dsp_put_rep) begin
            rep_word <= dsp_wdata;
            rep_n_q  <= 1'b0;
        end else if (ops.host_take_rep) begin
            rep_n_q  <= 1'b1;
        end
    end

    assign flags.cmd_fresh_n = cmd_n_q;
    assign flags.rep_fresh_n = rep_n_q;

    assert_cmd_store_R2: assert property (@(posedge clk) disable iff (rst)
        ops.host_put_cmd |=> (cmd_word == $past(host_wdata)) && flags.cmd_fresh_n);

    assert_cmd_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (ops.dsp_take_cmd && !ops.host_put_cmd) |=> !flags.cmd_fresh_n && $stable(cmd_word));

    assert_rep_store_R4: assert property (@(posedge clk) disable iff (rst)
        ops.dsp_put_rep |=> (rep_word == $past(dsp_wdata)) && !flags.rep_fresh_n);

    assert_rep_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (ops.host_take_rep && !ops.dsp_put_rep) |=> flags.rep_fresh_n && $stable(rep_word));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ops == '0) |=> $stable(cmd_word) && $stable(rep_word) && $stable(flags));

endmodule

// File: rtl/dsp_mbox_status.sv
module dsp_mbox_status
    import dsp_mbox_pkg::*;
#(
    parameter int NUM_LANES = 3
) (
    input  lane_flags_t [NUM_LANES-1:0] flags,
    input  logic        [NUM_LANES-1:0] irq_en,
    output logic        [STATUS_W-1:0]  status,
    output logic                        irq
);

    logic [NUM_LANES-1:0] pending;

    always_comb begin
        // Unused lane slots read idle (1); low bits read 0.
        status = '0;
        status[STATUS_W-1:REPLY_FLAG_LO] = '1;
        for (int i = 0; i < NUM_LANES; i++) begin
            status[REPLY_FLAG_LO + i] = flags[i].rep_fresh_n;
            status[CMD_FLAG_LO + i]   = flags[i].cmd_fresh_n;
            pending[i] = irq_en[i] & ~flags[i].rep_fresh_n;
        end
    end

    assign irq = |pending;

endmodule

// File: rtl/dsp_mailbox.sv
module dsp_mailbox
    import dsp_mbox_pkg::*;
#(
    parameter  int NUM_LANES = 3,
    parameter  int DATA_W    = 16,
    localparam int ADDR_W    = (NUM_LANES > 2) ? $clog2(NUM_LANES + 1) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic                 host_wr_en,
    input  logic                 host_rd_en,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    input  logic [NUM_LANES-1:0] irq_en,
    output logic [STATUS_W-1:0]  status,
    output logic                 irq,
    input  logic [ADDR_W-1:0]    dsp_addr,
    input  logic                 dsp_wr_en,
    input  logic                 dsp_rd_en,
    input  logic [DATA_W-1:0]    dsp_wdata,
    output logic [DATA_W-1:0]    dsp_rdata
);

    lane_ops_t   [NUM_LANES-1:0] ops;
    lane_flags_t [NUM_LANES-1:0] flags;
    logic        [DATA_W-1:0]    cmd_words [NUM_LANES];
    logic        [DATA_W-1:0]    rep_words [NUM_LANES];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        always_comb begin
            ops[g].host_put_cmd  = lane_hit(host_wr_en, int'(host_addr), g);
            ops[g].host_take_rep = lane_hit(host_rd_en, int'(host_addr), g);
            ops[g].dsp_put_rep   = lane_hit(dsp_wr_en,  int'(dsp_addr),  g);
            ops[g].dsp_take_cmd  = lane_hit(dsp_rd_en,  int'(dsp_addr),  g);
        end

        dsp_mbox_lane #(.DATA_W(DATA_W)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .ops        (ops[g]),
            .host_wdata (host_wdata),
            .dsp_wdata  (dsp_wdata),
            .cmd_word   (cmd_words[g]),
            .rep_word   (rep_words[g]),
            .flags      (flags[g])
        );
    end

    // Read muxes; an index past the last lane returns zero.
    always_comb begin
        host_rdata = '0;
        dsp_rdata  = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (int'(host_addr) == i) host_rdata = rep_words[i];
            if (int'(dsp_addr)  == i) dsp_rdata  = cmd_words[i];
        end
    end

    dsp_mbox_status #(.NUM_LANES(NUM_LANES)) u_status (
        .flags  (flags),
        .irq_en (irq_en),
        .status (status),
        .irq    (irq)
    );

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq);

    assert_irq_needs_reply_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status[REPLY_FLAG_LO +: NUM_LANES] != '1));

    assert_low_status_R11: assert property (@(posedge clk) disable iff (rst)
        status[REPLY_FLAG_LO-1:0] == '0);

endmodule

// File: tb/dsp_mailbox_test.sv
`timescale 1ns/1ps
module dsp_mailbox_test;

    localparam int PERIOD = 20;

    logic        clk = 0;
    logic        rst = 1;
    logic [1:0]  host_addr = 0, dsp_addr = 0;
    logic        host_wr_en = 0, host_rd_en = 0, dsp_wr_en = 0, dsp_rd_en = 0;
    logic [15:0] host_wdata = 0, dsp_wdata = 0;
    logic [15:0] host_rdata, dsp_rdata, status;
    logic [2:0]  irq_en = 0;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;

    logic [15:0] m_cmd [3];
    logic [15:0] m_rep [3];
    logic        m_cn  [3];
    logic        m_rn  [3];

    always #(PERIOD/2) clk = ~clk;

    dsp_mailbox uut (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_en(irq_en), .status(status), .irq(irq),
        .dsp_addr(dsp_addr), .dsp_wr_en(dsp_wr_en), .dsp_rd_en(dsp_rd_en),
        .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_cmd[c] = 0; m_rep[c] = 0; m_cn[c] = 1; m_rn[c] = 1;
        end
    endtask

    // One clock with the given strobes; expected state updated from the rules.
    task automatic cycle(input logic hw, input logic hr, input logic [1:0] ha,
                         input logic [15:0] hd, input logic dw, input logic dr,
                         input logic [1:0] da, input logic [15:0] dd);
        host_wr_en = hw; host_rd_en = hr; host_addr = ha; host_wdata = hd;
        dsp_wr_en  = dw; dsp_rd_en  = dr; dsp_addr  = da; dsp_wdata  = dd;
        @(posedge clk);
        for (int c = 0; c < 3; c++) begin
            if (hw && ha == c) begin m_cmd[c] = hd; m_cn[c] = 1; end
            else if (dr && da == c) m_cn[c] = 0;
            if (dw && da == c) begin m_rep[c] = dd; m_rn[c] = 0; end
            else if (hr && ha == c) m_rn[c] = 1;
        end
        @(negedge clk);
        host_wr_en = 0; host_rd_en = 0; dsp_wr_en = 0; dsp_rd_en = 0;
    endtask

    task automatic check_all(input string tag);
        logic [15:0] exp_st;
        logic        exp_irq;
        exp_st = 0; exp_irq = 0;
        for (int c = 0; c < 3; c++) begin
            exp_st = exp_st | (16'(m_rn[c]) << (10 + c)) | (16'(m_cn[c]) << (13 + c));
            exp_irq = exp_irq | (irq_en[c] & ~m_rn[c]);
        end
        #1;
        chk({tag, " status"}, 32'(status), 32'(exp_st));
        chk({tag, " irq"}, 32'(irq), 32'(exp_irq));
        for (int a = 0; a < 4; a++) begin
            host_addr = 2'(a); dsp_addr = 2'(a);
            #1;
            chk({tag, " host_rdata"}, 32'(host_rdata), (a < 3) ? 32'(m_rep[a]) : 32'h0);
            chk({tag, " dsp_rdata"},  32'(dsp_rdata),  (a < 3) ? 32'(m_cmd[a]) : 32'h0);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        model_reset();
        irq_en = 3'b111;
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R1");
        chk("R11 low status bits", 32'(status[9:0]), 32'h0);

        // R2/R3: walking-one commands on every lane, then DSP acknowledge.
        for (int c = 0; c < 3; c++) begin
            for (int k = 0; k < 16; k++) begin
                v = (16'h1 << k) ^ (16'(c) * 16'h1111);
                cycle(1, 0, 2'(c), v, 0, 0, 0, 0);
                check_all("R2");
                cycle(0, 0, 0, 0, 0, 1, 2'(c), 0);
                check_all("R3");
            end
        end

        // R4/R5: walking-one replies, then host acknowledge.
        for (int c = 0; c < 3; c++) begin
            for (int k = 0; k < 16; k++) begin
                v = ~(16'h1 << k) ^ (16'(c) * 16'h0303);
                cycle(0, 0, 0, 0, 1, 0, 2'(c), v);
                check_all("R4");
                cycle(0, 1, 2'(c), 0, 0, 0, 0, 0);
                check_all("R5");
            end
        end

        // R6: same-lane command collision, then cross-lane pair.
        for (int c = 0; c < 3; c++) begin
            cycle(0, 0, 0, 0, 0, 1, 2'(c), 0);
            cycle(1, 0, 2'(c), 16'hC0DE + 16'(c), 0, 1, 2'(c), 0);
            check_all("R6");
        end
        cycle(1, 0, 2'd0, 16'h1234, 0, 1, 2'd1, 0);
        check_all("R9 cross-lane");

        // R7: same-lane reply collision.
        for (int c = 0; c < 3; c++) begin
            cycle(0, 1, 2'(c), 0, 1, 0, 2'(c), 16'hBEE0 + 16'(c));
            check_all("R7");
        end
        cycle(0, 1, 2'd2, 0, 1, 0, 2'd0, 16'h5A5A);
        check_all("R9 cross-lane");

        // R8: every enable mask against every pending-reply pattern.
        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 3; c++) cycle(0, 1, 2'(c), 0, 0, 0, 0, 0);
            for (int c = 0; c < 3; c++)
                if (p[c]) cycle(0, 0, 0, 0, 1, 0, 2'(c), 16'(p * 7 + c));
            for (int m = 0; m < 8; m++) begin
                irq_en = 3'(m);
                check_all("R8");
            end
        end

        // R10: index 3 on both ports changes nothing.
        irq_en = 3'b111;
        cycle(1, 0, 2'd3, 16'hDEAD, 0, 0, 0, 0);
        check_all("R10");
        cycle(0, 0, 0, 0, 0, 1, 2'd3, 0);
        check_all("R10");
        cycle(0, 0, 0, 0, 1, 0, 2'd3, 16'hFACE);
        check_all("R10");
        cycle(0, 1, 2'd3, 0, 0, 0, 0, 0);
        check_all("R10");
        chk("R11 low status bits", 32'(status[9:0]), 32'h0);

        // Reset again from a busy state.
        rst = 1;
        @(negedge clk);
        rst = 0;
        model_reset();
        check_all("R1 re-reset");

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule